// File: doc/BRIEF.md
# VLIW Bundle Length Decoder

This block sits in the fetch stage of a VLIW core. It looks at a 128-bit window of fetched instruction bits, whose lowest bit is the start of the next issue group, and decides how much of that window forms one group. A group is a lone 16-bit compressed operation, or one to three 32-bit words that issue together in one clock. The same chaining mechanism also carries large constants: a jumbo form is a chain of one or two prefix words followed by a single operation. The block joins the payload of the prefixes with a field of the operation into one immediate, either 33 bits or a full 64 bits, so that a 64-bit constant load issues as a single operation in one cycle. Groupings that break the chaining rules are flagged as illegal.

Decoding is combinational from the window. One register stage holds the decoded group toward decode, with a valid/ready handshake on both sides. A window is taken on a clock edge where `win_valid` and `win_ready` are both high. `win_ready` is high whenever the output stage is empty or its content is taken in the same cycle, so one group per clock flows with no stall. While decode holds `dec_ready` low with `dec_valid` high, the held group does not change. Fetch must then keep `win_valid` and `win_data` steady until they are taken.

Top module: `vliw_group_splitter`

## Requirements
- R1: A window taken on a clock edge (win_valid and win_ready both high) appears decoded on the dec_* outputs with dec_valid high from the next cycle on. win_ready is high exactly when dec_valid is low or dec_ready is high.
- R2: While dec_valid is high and dec_ready is low, dec_valid stays high on the next cycle and every dec_* field holds its value.
- R3: If window bits [1:0] are not 2'b11, the group is a 16-bit operation: dec_len = 0, dec_lanes = 1, dec_words = {80'h0, window[15:0]}, no immediate and no illegal flag, whatever the remaining bits hold.
- R4: A 32-bit word has bits [1:0] = 2'b11. Bit 31 is its continuation flag. A first word with bit 31 clear whose opcode field (bits [6:2]) is not the prefix value (default 5'h1F) gives dec_len = 1 (32 bits), dec_lanes = 1, and lane 0 = window[31:0].
- R5: A chain of two or three non-prefix words (word k at window[32k+31:32k]; every word except the last has bit 31 set) gives dec_len = 2 (64 bits) or 3 (96 bits), with dec_lanes equal to the word count. Lane k sits at dec_words[32k+31:32k], and unused lanes read zero.
- R6: A third word with its continuation flag set makes the group illegal.
- R7: A 16-bit parcel (bits [1:0] not 2'b11) in the second or third word slot, reached while a continuation is pending, makes the group illegal.
- R8: A prefix word chained to one final non-prefix word is a 64-bit jumbo form: dec_len = 2, dec_lanes = 1, lane 0 = the final word, dec_imm_kind = 1. dec_imm is {prefix[30:7], final[30:22]} sign-extended from 33 to 64 bits.
- R9: Two chained prefix words followed by a non-prefix final word form the 96-bit jumbo form: dec_len = 3, dec_lanes = 1, lane 0 = the third word, dec_imm_kind = 2, and dec_imm = {word0[30:7], word1[30:7], word2[30:15]}.
- R10: A prefix word as the last word of a chain, a prefix word after a non-prefix first word, or a non-prefix second word between a prefix and a third word makes the group illegal.
- R11: An illegal group reports dec_illegal = 1, dec_len = 1, dec_lanes = 1, lane 0 = window[31:0], the other lanes zero, dec_imm_kind = 0 and dec_imm = 0. Every legal non-jumbo group reports dec_imm_kind = 0 and dec_imm = 0.
- R12: After reset, dec_valid is low and win_ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_valid | input | 1 | Fetch window is valid |
| win_ready | output | 1 | Block can take a window this cycle |
| win_data | input | 128 | Fetch window, next group starting at bit 0 |
| dec_valid | output | 1 | Decoded group is valid |
| dec_ready | input | 1 | Decode takes the group this cycle |
| dec_len | output | 2 | Group length code: 0=16, 1=32, 2=64, 3=96 bits |
| dec_lanes | output | 2 | Operation lanes used, 1 to 3 |
| dec_words | output | 96 | Lane words, lane k at bits [32k+31:32k] |
| dec_imm_kind | output | 2 | Immediate kind: 0 none, 1 33-bit, 2 64-bit |
| dec_imm | output | 64 | Assembled immediate, sign-extended for kind 1 |
| dec_illegal | output | 1 | Group breaks the chaining rules |

## Verification
On every cycle the assertions check the handshake: a taken window leads to a valid output, and a stalled output holds still. They also check that the output fields agree with each other: lane count against length code, immediate kind against length, the zeroed lanes of 16-bit, illegal and jumbo groups, and the fixed shape of an illegal report. Whether a given window gets the right length, the right illegal cause, the right lane words and the right assembled immediate, including sign extension of the 33-bit form and the order of the 64-bit payload slices, can only be shown by the bench. It compares every delivered group with a reference model while random back-pressure stalls the output.

// File: rtl/vgs_pkg.sv
package vgs_pkg;
  localparam int WORD_W  = 32;
  localparam int LANES   = 3;
  localparam int HALF_W  = 16;
  localparam int IMM_W   = 64;
  localparam int OPC_LO  = 2;
  localparam int OPC_W   = 5;
  localparam int PAY_LO  = OPC_LO + OPC_W;
  localparam int PAY_HI  = WORD_W - 2;
  localparam int PAY_W   = PAY_HI - PAY_LO + 1;
  localparam int T33_W   = 9;
  localparam int T64_W   = IMM_W - 2 * PAY_W;
  localparam int IMM33_W = PAY_W + T33_W;
  localparam int GRP_W   = LANES * WORD_W;

  typedef enum logic [1:0] {LEN16 = 2'd0, LEN32 = 2'd1, LEN64 = 2'd2, LEN96 = 2'd3} len_e;
  typedef enum logic [1:0] {IMM_NONE = 2'd0, IMM_33 = 2'd1, IMM_64 = 2'd2} imm_e;

  typedef struct packed {
    len_e             len;
    logic [1:0]       lanes;
    logic [GRP_W-1:0] words;
    imm_e             kind;
    logic [IMM_W-1:0] imm;
    logic             illegal;
  } grp_t;
endpackage

// File: rtl/vgs_parcel_class.sv
module vgs_parcel_class
  import vgs_pkg::*;
#(
  parameter logic [OPC_W-1:0] JUMBO_OP = 5'h1F
) (
  input  logic [PAY_LO-1:0] low_bits,
  input  logic              top_bit,
  output logic              is_wide,
  output logic              has_cont,
  output logic              is_prefix
);
  assign is_wide   = (low_bits[1:0] == 2'b11);
  assign has_cont  = top_bit;
  assign is_prefix = is_wide && (low_bits[OPC_LO +: OPC_W] == JUMBO_OP);
endmodule

// File: rtl/vgs_group_resolve.sv
module vgs_group_resolve
  import vgs_pkg::*;
(
  input  logic [LANES-1:0] wide,
  input  logic [LANES-1:0] cont,
  input  logic [LANES-1:0] pfx,
  input  logic [GRP_W-1:0] words,
  output len_e             len,
  output logic [1:0]       lanes,
  output imm_e             kind,
  output logic             illegal,
  output logic [GRP_W-1:0] lane_words
);
  typedef enum logic [2:0] {F_HALF, F_ONE, F_TWO, F_THREE, F_J33, F_J64, F_BAD} form_e;

  form_e form;

  // walk the chain from the first word
  always_comb begin
    form = F_BAD;
    if (!wide[0]) begin
      form = F_HALF;
    end else if (!cont[0]) begin
      form = pfx[0] ? F_BAD : F_ONE;
    end else if (!wide[1]) begin
      form = F_BAD;
    end else if (!cont[1]) begin
      if (pfx[1])      form = F_BAD;
      else if (pfx[0]) form = F_J33;
      else             form = F_TWO;
    end else if (!wide[2] || cont[2] || pfx[2]) begin
      form = F_BAD;
    end else if (pfx[0] && pfx[1]) begin
      form = F_J64;
    end else if (pfx[0] || pfx[1]) begin
      form = F_BAD;
    end else begin
      form = F_THREE;
    end
  end

  always_comb begin
    len        = LEN32;
    lanes      = 2'd1;
    kind       = IMM_NONE;
    illegal    = 1'b0;
    lane_words = '0;
    unique case (form)
      F_HALF: begin
        len                     = LEN16;
        lane_words[HALF_W-1:0]  = words[HALF_W-1:0];
      end
      F_ONE: lane_words[WORD_W-1:0] = words[WORD_W-1:0];
      F_TWO: begin
        len                       = LEN64;
        lanes                     = 2'd2;
        lane_words[2*WORD_W-1:0]  = words[2*WORD_W-1:0];
      end
      F_THREE: begin
        len        = LEN96;
        lanes      = 2'd3;
        lane_words = words;
      end
      F_J33: begin
        len                      = LEN64;
        kind                     = IMM_33;
        lane_words[WORD_W-1:0]   = words[WORD_W +: WORD_W];
      end
      F_J64: begin
        len                      = LEN96;
        kind                     = IMM_64;
        lane_words[WORD_W-1:0]   = words[2*WORD_W +: WORD_W];
      end
      default: begin
        illegal                  = 1'b1;
        lane_words[WORD_W-1:0]   = words[WORD_W-1:0];
      end
    endcase
  end
endmodule

// File: rtl/vgs_imm_build.sv
module vgs_imm_build
  import vgs_pkg::*;
(
  input  imm_e             kind,
  input  logic [PAY_W-1:0] pay0,
  input  logic [PAY_W-1:0] pay1,
  input  logic [T33_W-1:0] tail33,
  input  logic [T64_W-1:0] tail64,
  output logic [IMM_W-1:0] imm
);
  logic [IMM33_W-1:0] short_val;

  assign short_val = {pay0, tail33};

  always_comb begin
    unique case (kind)
      IMM_33:  imm = {{(IMM_W - IMM33_W){short_val[IMM33_W-1]}}, short_val};
      IMM_64:  imm = {pay0, pay1, tail64};
      default: imm = '0;
    endcase
  end
endmodule

// File: rtl/vgs_out_slice.sv
module vgs_out_slice
  import vgs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  output logic in_ready,
  input  grp_t in_grp,
  output logic out_valid,
  input  logic out_ready,
  output grp_t out_grp
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_grp   <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (in_valid && in_ready) out_grp <= in_grp;
    end
  end
endmodule

// File: rtl/vliw_group_splitter.sv
module vliw_group_splitter
  import vgs_pkg::*;
#(
  parameter int               WIN_W    = 128,
  parameter logic [OPC_W-1:0] JUMBO_OP = 5'h1F
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_valid,
  output logic             win_ready,
  input  logic [WIN_W-1:0] win_data,
  output logic             dec_valid,
  input  logic             dec_ready,
  output logic [1:0]       dec_len,
  output logic [1:0]       dec_lanes,
  output logic [GRP_W-1:0] dec_words,
  output logic [1:0]       dec_imm_kind,
  output logic [IMM_W-1:0] dec_imm,
  output logic             dec_illegal
);
  localparam int SPARE_W = WIN_W - GRP_W;

  logic [GRP_W-1:0] words;
  logic [LANES-1:0] wide, cont, pfx;
  len_e             r_len;
  logic [1:0]       r_lanes;
  imm_e             r_kind;
  logic             r_illegal;
  logic [GRP_W-1:0] r_lane_words;
  logic [IMM_W-1:0] r_imm;
  grp_t             cur_grp, held_grp;

  assign words = win_data[GRP_W-1:0];

  generate
    if (SPARE_W > 0) begin : g_spare
      logic unused_spare;
      assign unused_spare = ^win_data[WIN_W-1:GRP_W];
    end
  endgenerate

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_class
      vgs_parcel_class #(.JUMBO_OP(JUMBO_OP)) i_class (
        .low_bits (words[k*WORD_W +: PAY_LO]),
        .top_bit  (words[k*WORD_W + WORD_W - 1]),
        .is_wide  (wide[k]),
        .has_cont (cont[k]),
        .is_prefix(pfx[k])
      );
    end
  endgenerate

  vgs_group_resolve i_resolve (
    .wide      (wide),
    .cont      (cont),
    .pfx       (pfx),
    .words     (words),
    .len       (r_len),
    .lanes     (r_lanes),
    .kind      (r_kind),
    .illegal   (r_illegal),
    .lane_words(r_lane_words)
  );

  vgs_imm_build i_imm (
    .kind  (r_kind),
    .pay0  (words[PAY_LO +: PAY_W]),
    .pay1  (words[WORD_W + PAY_LO +: PAY_W]),
    .tail33(words[WORD_W + PAY_HI - T33_W + 1 +: T33_W]),
    .tail64(words[2*WORD_W + PAY_HI - T64_W + 1 +: T64_W]),
    .imm   (r_imm)
  );

  always_comb begin
    cur_grp.len     = r_len;
    cur_grp.lanes   = r_lanes;
    cur_grp.words   = r_lane_words;
    cur_grp.kind    = r_kind;
    cur_grp.imm     = r_imm;
    cur_grp.illegal = r_illegal;
  end

  vgs_out_slice i_slice (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (win_valid),
    .in_ready (win_ready),
    .in_grp   (cur_grp),
    .out_valid(dec_valid),
    .out_ready(dec_ready),
    .out_grp  (held_grp)
  );

  assign dec_len      = held_grp.len;
  assign dec_lanes    = held_grp.lanes;
  assign dec_words    = held_grp.words;
  assign dec_imm_kind = held_grp.kind;
  assign dec_imm      = held_grp.imm;
  assign dec_illegal  = held_grp.illegal;
endmodule

// File: rtl/vgs_checker.sv
module vgs_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        win_valid,
  input logic        win_ready,
  input logic        dec_valid,
  input logic        dec_ready,
  input logic [1:0]  dec_len,
  input logic [1:0]  dec_lanes,
  input logic [95:0] dec_words,
  input logic [1:0]  dec_imm_kind,
  input logic [63:0] dec_imm,
  input logic        dec_illegal
);
  a_r1_accept_gives_valid: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid && win_ready |=> dec_valid);

  a_r2_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && !dec_ready |=> dec_valid && $stable(dec_len) && $stable(dec_lanes)
      && $stable(dec_words) && $stable(dec_imm_kind) && $stable(dec_imm) && $stable(dec_illegal));

  a_r3_half_alone: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && dec_len == 2'd0 |-> dec_lanes == 2'd1 && dec_words[95:16] == '0
      && !dec_illegal && dec_imm_kind == 2'd0);

  a_r5_lanes_follow_len: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && !dec_illegal && dec_imm_kind == 2'd0 && dec_len != 2'd0 |-> dec_lanes == dec_len);

  a_r8_imm33_shape: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && dec_imm_kind == 2'd1 |-> dec_len == 2'd2 && dec_lanes == 2'd1 && dec_words[95:32] == '0);

  a_r9_imm64_shape: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && dec_imm_kind == 2'd2 |-> dec_len == 2'd3 && dec_lanes == 2'd1 && dec_words[95:32] == '0);

  a_r11_illegal_shape: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && dec_illegal |-> dec_len == 2'd1 && dec_lanes == 2'd1 && dec_imm_kind == 2'd0
      && dec_imm == '0 && dec_words[95:32] == '0);

  a_r11_no_stray_imm: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && dec_imm_kind == 2'd0 |-> dec_imm == '0);
endmodule

bind vliw_group_splitter vgs_checker i_vgs_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .win_valid   (win_valid),
  .win_ready   (win_ready),
  .dec_valid   (dec_valid),
  .dec_ready   (dec_ready),
  .dec_len     (dec_len),
  .dec_lanes   (dec_lanes),
  .dec_words   (dec_words),
  .dec_imm_kind(dec_imm_kind),
  .dec_imm     (dec_imm),
  .dec_illegal (dec_illegal)
);

// File: tb/test_vliw_group_splitter.sv
module test_vliw_group_splitter;
  import vgs_pkg::*;

  localparam int          NTX  = 3000;
  localparam int          NDIR = 10;
  localparam logic [4:0]  JOP  = 5'h1F;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         win_valid;
  logic         win_ready;
  logic [127:0] win_data;
  logic         dec_valid;
  logic         dec_ready;
  logic [1:0]   dec_len;
  logic [1:0]   dec_lanes;
  logic [95:0]  dec_words;
  logic [1:0]   dec_imm_kind;
  logic [63:0]  dec_imm;
  logic         dec_illegal;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  vliw_group_splitter i_vliw_group_splitter (
    .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_ready(win_ready),
    .win_data(win_data), .dec_valid(dec_valid), .dec_ready(dec_ready),
    .dec_len(dec_len), .dec_lanes(dec_lanes), .dec_words(dec_words),
    .dec_imm_kind(dec_imm_kind), .dec_imm(dec_imm), .dec_illegal(dec_illegal)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  function automatic logic [31:0] mkw(input bit c, input logic [4:0] op, input logic [23:0] body);
    return {c, body, op, 2'b11};
  endfunction

  function automatic logic [31:0] opw(input bit c);
    return mkw(c, 5'($urandom % 31), 24'($urandom));
  endfunction

  function automatic logic [31:0] pfw(input bit c);
    return mkw(c, JOP, 24'($urandom));
  endfunction

  function automatic logic [31:0] halfw();
    logic [31:0] r;
    r = $urandom;
    r[1:0] = 2'($urandom % 3);
    return r;
  endfunction

  function automatic bit is_pfx(input logic [31:0] w);
    return (w[1:0] == 2'b11) && (w[6:2] == JOP);
  endfunction

  // reference decode from the requirements
  function automatic grp_t ref_grp(input logic [127:0] w, output string tag);
    logic [31:0] w0, w1, w2;
    grp_t g;
    int n;
    bit bad, p0, p1, plast;
    w0 = w[31:0]; w1 = w[63:32]; w2 = w[95:64];
    g = '0; tag = ""; n = 1; bad = 0;
    if (w0[1:0] != 2'b11) begin
      g.len = LEN16; g.lanes = 2'd1; g.words = {80'h0, w0[15:0]};
      tag = "R3";
      return g;
    end
    if (w0[31]) begin
      if (w1[1:0] != 2'b11) begin bad = 1; tag = "R7"; end
      else begin
        n = 2;
        if (w1[31]) begin
          if (w2[1:0] != 2'b11) begin bad = 1; tag = "R7"; end
          else if (w2[31])      begin bad = 1; tag = "R6"; end
          else n = 3;
        end
      end
    end
    p0 = is_pfx(w0); p1 = is_pfx(w1);
    plast = (n == 1) ? p0 : (n == 2) ? p1 : is_pfx(w2);
    if (!bad) begin
      if (plast)                  begin bad = 1; tag = "R10"; end
      else if (n == 3 && p0 != p1) begin bad = 1; tag = "R10"; end
    end
    if (bad) begin
      g.len = LEN32; g.lanes = 2'd1; g.words = {64'h0, w0}; g.illegal = 1'b1;
      tag = {tag, ",R11"};
      return g;
    end
    if (p0 && n == 2) begin
      g.len = LEN64; g.lanes = 2'd1; g.words = {64'h0, w1}; g.kind = IMM_33;
      g.imm = {{31{w0[30]}}, w0[30:7], w1[30:22]};
      tag = "R8";
    end else if (p0) begin
      g.len = LEN96; g.lanes = 2'd1; g.words = {64'h0, w2}; g.kind = IMM_64;
      g.imm = {w0[30:7], w1[30:7], w2[30:15]};
      tag = "R9";
    end else begin
      g.lanes = 2'(n);
      case (n)
        1: begin g.len = LEN32; g.words = {64'h0, w0}; tag = "R4"; end
        2: begin g.len = LEN64; g.words = {32'h0, w1, w0}; tag = "R5"; end
        default: begin g.len = LEN96; g.words = {w2, w1, w0}; tag = "R5"; end
      endcase
    end
    return g;
  endfunction

  function automatic logic [127:0] next_window(input int i);
    logic [31:0] junk;
    int sel;
    junk = $urandom;
    sel = (i < NDIR) ? i : 10 + int'($urandom % 10);
    case (sel)
      0: return {junk, pfw(1), opw(1), 16'hFFFF, 16'h1234};                // R3 lone half
      1: return {junk, pfw(1), pfw(1), opw(0)};                            // R4
      2: return {junk, opw(0), opw(1), opw(1)};                            // R5 three lanes
      3: return {junk, opw(1), opw(1), opw(1)};                            // R6
      4: return {junk, opw(0), halfw(), opw(1)};                           // R7
      5: return {junk, opw(0), mkw(0, 5'h03, 24'h0), mkw(1, JOP, 24'h800001)}; // R8 negative
      6: return {junk, mkw(0, 5'h04, 24'hABCDEF), mkw(1, JOP, 24'h123456), mkw(1, JOP, 24'hFEDCBA)}; // R9
      7: return {junk, opw(1), opw(1), pfw(0)};                            // R10 prefix alone
      8: return {junk, opw(0), pfw(1), opw(1)};                            // R10 mixed
      9: return {junk, opw(0), opw(1), pfw(1)};                            // R10 prefix then two ops
      10: return {junk, opw(1), opw(1), halfw()};
      11: return {junk, opw(1), opw(1), opw(0)};
      12: return {junk, opw(1), opw(0), opw(1)};
      13: return {junk, opw(0), opw(1), opw(1)};
      14: return {junk, opw(1), opw(0), pfw(1)};
      15: return {junk, opw(0), pfw(1), pfw(1)};
      16: return {junk, (($urandom % 2) != 0) ? opw(1) : halfw(), opw(1), opw(1)};
      17: return {junk, opw($urandom % 2), (($urandom % 2) != 0) ? pfw(1) : opw(1), pfw(1)};
      default: return {junk, 32'($urandom), 32'($urandom), 32'($urandom)};
    endcase
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL R1 watchdog expired: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin : main
    grp_t  q[$];
    string tq[$];
    grp_t  snap;
    bit    snap_on;
    bit    taken;
    int    sent;
    grp_t  e;
    string t;
    void'($urandom(32'd7321));
    rst_n = 1'b0; win_valid = 1'b0; win_data = '0; dec_ready = 1'b0;
    snap_on = 0; taken = 0; sent = 0; snap = '0;
    repeat (3) @(negedge clk);
    check(dec_valid == 1'b0, "R12", "dec_valid in reset", 128'(dec_valid), 128'd0);
    check(win_ready == 1'b1, "R12", "win_ready in reset", 128'(win_ready), 128'd1);
    rst_n = 1'b1;
    while (sent < NTX || q.size() != 0) begin
      @(negedge clk);
      if (snap_on) begin
        check(dec_valid == 1'b1 && dec_len == snap.len && dec_lanes == snap.lanes
              && dec_words == snap.words && dec_imm_kind == snap.kind
              && dec_imm == snap.imm && dec_illegal == snap.illegal,
              "R2", "held group changed", 128'(dec_words), 128'(snap.words));
        snap_on = 0;
      end
      if (taken) begin win_valid = 1'b0; taken = 0; end
      if (!win_valid && sent < NTX && ($urandom % 4) != 0) begin
        win_data  = next_window(sent);
        win_valid = 1'b1;
      end
      dec_ready = (sent < NTX) ? (($urandom % 3) != 0) : 1'b1;
      #1;
      check(win_ready == (!dec_valid || dec_ready), "R1", "win_ready rule",
            128'(win_ready), 128'(!dec_valid || dec_ready));
      if (dec_valid && dec_ready) begin
        if (q.size() == 0) begin
          check(1'b0, "R1", "output with nothing taken", 128'(dec_valid), 128'd0);
        end else begin
          e = q.pop_front();
          t = tq.pop_front();
          check(dec_len == e.len, t, "dec_len", 128'(dec_len), 128'(e.len));
          check(dec_lanes == e.lanes, t, "dec_lanes", 128'(dec_lanes), 128'(e.lanes));
          check(dec_words == e.words, t, "dec_words", 128'(dec_words), 128'(e.words));
          check(dec_imm_kind == e.kind && dec_imm == e.imm, t, "dec_imm",
                {62'h0, dec_imm_kind, dec_imm}, {62'h0, e.kind, e.imm});
          check(dec_illegal == e.illegal, t, "dec_illegal", 128'(dec_illegal), 128'(e.illegal));
        end
      end else if (dec_valid) begin
        snap = {dec_len, dec_lanes, dec_words, dec_imm_kind, dec_imm, dec_illegal};
        snap_on = 1;
      end else if (q.size() != 0) begin
        check(1'b0, "R1", "taken window not presented", 128'(dec_valid), 128'd1);
        void'(q.pop_front());
        void'(tq.pop_front());
      end
      if (win_valid && win_ready) begin
        e = ref_grp(win_data, t);
        q.push_back(e);
        tq.push_back(t);
        sent++;
        taken = 1;
      end
    end
    @(negedge clk);
    win_valid = 1'b0;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule